// File: doc/BRIEF.md
# Retirement Trace Consistency Checker

This block watches the per-retirement trace port of a RISC-V core. Each cycle in which the trace is marked valid, it tests the retiring instruction on its own and against the one retired before it. The tests cover gap-free numbering of retirements, agreement between the redirect flag and the program-counter chain, zero data for register slot zero, clean upper bits in the instruction word, legal privilege and register-width encodings, and retirements that arrive after a halt. It has no model of the instruction set and does not judge whether any result is correct.

Each broken rule sets its own bit in a sticky error vector. A separate code register records which rule failed first. A saturating counter reports how many valid retirements have been examined. The block is meant to sit next to a core in simulation or emulation, or in silicon as a cheap sanity monitor. Widths of the program counter, instruction word, order index, register addresses and counter are all parameters.

Top module: `trc_retire_checker`

## Requirements
- R1: When a valid retirement is not the first since reset and its order is not the previous valid order plus one (modulo 2^ORDER_W), error bit 0 sets. A repeated or skipped index both count. The next expected order then follows the observed value.
- R2: When a valid retirement is not the first since reset, error bit 1 sets if the intr flag differs from "pc before this instruction differs from the pc after the previous valid retirement".
- R3: A valid retirement with rd address zero and nonzero rd data sets error bit 2.
- R4: A valid retirement with rs1 address zero and nonzero rs1 data, or rs2 address zero and nonzero rs2 data, sets error bit 3.
- R5: An instruction word whose bits [1:0] are not 2'b11 is a 16-bit instruction, and any set bit from bit 16 upward sets error bit 4. Otherwise it is a 32-bit instruction, and any set bit from bit 32 upward sets error bit 4.
- R6: A valid retirement with mode equal to 2 (reserved) sets error bit 5. Mode values 0 (user), 1 (supervisor) and 3 (machine) are legal.
- R7: A valid retirement with ixl not equal to 1 (32-bit) or 2 (64-bit) sets error bit 6.
- R8: Any valid retirement after a valid retirement that carried halt sets error bit 7. The halting retirement itself is not flagged.
- R9: Reset clears all error bits, the first-error code and the count. Error bits stay set until reset.
- R10: The first-error code is 0 while no error has been seen. It then holds the lowest error bit index plus one among the rules broken by the first failing retirement, and keeps that value until reset.
- R11: Each valid retirement increments the checked count by one, saturating at all ones. All outputs update at the clock edge that samples the retirement.
- R12: When valid is low, all trace fields are ignored. No output changes, and the ordering, pc and halt history are untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trc_valid | input | 1 | A retirement is presented this cycle |
| trc_order | input | ORDER_W | Retirement index |
| trc_pc_pre | input | XLEN | pc of the retiring instruction |
| trc_pc_post | input | XLEN | pc of the next instruction |
| trc_insn | input | INSN_W | Retired instruction word |
| trc_halt | input | 1 | Last retirement before halting |
| trc_intr | input | 1 | First instruction of a handler |
| trc_mode | input | 2 | Privilege level |
| trc_ixl | input | 2 | Register width code |
| trc_rd_addr | input | RADDR_W | Destination register address |
| trc_rd_data | input | XLEN | Destination write data |
| trc_rs1_addr | input | RADDR_W | First source register address |
| trc_rs1_data | input | XLEN | First source read data |
| trc_rs2_addr | input | RADDR_W | Second source register address |
| trc_rs2_data | input | XLEN | Second source read data |
| err_flags | output | 8 | Sticky per-rule error bits |
| err_first | output | 4 | Code of first failing rule |
| checked_cnt | output | CNT_W | Saturating count of checked retirements |

## Verification
The bench builds the block with XLEN=32, INSN_W=64, ORDER_W=8 and CNT_W=6. The 8-bit order lets a short run cross the 255-to-0 wrap of the index. The 64-bit instruction word exercises both the 16-bit and the 32-bit upper-bit rules. The 6-bit counter reaches saturation after 63 retirements. A reference model in the bench tracks the expected error vector, first code and count for every retirement, every idle cycle and every reset.

// File: rtl/trc_chk_pkg.sv
package trc_chk_pkg;

   localparam int NUM_RULES = 8;
   localparam int CODE_W    = $clog2(NUM_RULES + 1);

   localparam int RULE_ORDER     = 0;
   localparam int RULE_INTR      = 1;
   localparam int RULE_RD_ZERO   = 2;
   localparam int RULE_RS_ZERO   = 3;
   localparam int RULE_INSN_HI   = 4;
   localparam int RULE_MODE      = 5;
   localparam int RULE_IXL       = 6;
   localparam int RULE_POST_HALT = 7;

   localparam logic [1:0] MODE_RESERVED = 2'd2;
   localparam logic [1:0] IXL_W32       = 2'd1;
   localparam logic [1:0] IXL_W64       = 2'd2;
   localparam logic [1:0] INSN_FULL_LO  = 2'b11;

   typedef logic [NUM_RULES-1:0] rule_vec_t;
   typedef logic [CODE_W-1:0]    rule_code_t;

   // lowest set index plus one, zero when nothing set
   function automatic rule_code_t first_code(rule_vec_t v);
      rule_code_t c;
      c = '0;
      for (int i = NUM_RULES - 1; i >= 0; i--) begin
         if (v[i]) c = CODE_W'(i + 1);
      end
      return c;
   endfunction

endpackage

// File: rtl/trc_field_rules.sv
module trc_field_rules
   import trc_chk_pkg::*;
#(
   parameter int XLEN    = 64,
   parameter int INSN_W  = 64,
   parameter int RADDR_W = 5,
   parameter int NUM_SRC = 2
) (
   input  logic [INSN_W-1:0]               insn,
   input  logic [1:0]                      mode,
   input  logic [1:0]                      ixl,
   input  logic [RADDR_W-1:0]              rd_addr,
   input  logic [XLEN-1:0]                 rd_data,
   input  logic [NUM_SRC-1:0][RADDR_W-1:0] rs_addr,
   input  logic [NUM_SRC-1:0][XLEN-1:0]    rs_data,
   output rule_vec_t                       viol
);

   logic [NUM_SRC-1:0] src_bad;
   logic               dst_bad;
   logic               is_short;
   logic               above16_set;
   logic               above32_set;
   logic               insn_bad;
   logic               unused_insn_mid;

   // one zero-slot check per source operand
   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      assign src_bad[s] = (rs_addr[s] == '0) && (rs_data[s] != '0);
   end

   assign dst_bad = (rd_addr == '0) && (rd_data != '0);

   assign is_short        = (insn[1:0] != INSN_FULL_LO);
   assign above16_set     = |insn[INSN_W-1:16];
   assign unused_insn_mid = ^insn[15:2];

   // a word of exactly 32 bits has no room above a full instruction
   if (INSN_W > 32) begin : g_wide_word
      assign above32_set = |insn[INSN_W-1:32];
   end else begin : g_exact_word
      assign above32_set = 1'b0;
   end

   assign insn_bad = is_short ? above16_set : above32_set;

   always_comb begin
      viol                 = '0;
      viol[RULE_RD_ZERO]   = dst_bad;
      viol[RULE_RS_ZERO]   = |src_bad;
      viol[RULE_INSN_HI]   = insn_bad;
      viol[RULE_MODE]      = (mode == MODE_RESERVED);
      viol[RULE_IXL]       = (ixl != IXL_W32) && (ixl != IXL_W64);
   end

endmodule

// File: rtl/trc_seq_rules.sv
module trc_seq_rules
   import trc_chk_pkg::*;
#(
   parameter int XLEN    = 64,
   parameter int ORDER_W = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               valid,
   input  logic [ORDER_W-1:0] order,
   input  logic [XLEN-1:0]    pc_pre,
   input  logic [XLEN-1:0]    pc_post,
   input  logic               halt,
   input  logic               intr,
   output rule_vec_t          viol
);

   logic               have_prev;
   logic               halted;
   logic [ORDER_W-1:0] prev_order;
   logic [XLEN-1:0]    prev_post;
   logic [ORDER_W-1:0] want_order;
   logic               redirect;

   assign want_order = prev_order + 1'b1;
   assign redirect   = (pc_pre != prev_post);

   always_comb begin
      viol                 = '0;
      viol[RULE_ORDER]     = have_prev && (order != want_order);
      viol[RULE_INTR]      = have_prev && (intr != redirect);
      viol[RULE_POST_HALT] = halted;
   end

   // history follows what was observed, so one defect flags once
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         have_prev  <= 1'b0;
         halted     <= 1'b0;
         prev_order <= '0;
         prev_post  <= '0;
      end else if (valid) begin
         have_prev  <= 1'b1;
         prev_order <= order;
         prev_post  <= pc_post;
         if (halt) halted <= 1'b1;
      end
   end

endmodule

// File: rtl/trc_err_log.sv
module trc_err_log
   import trc_chk_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             valid,
   input  rule_vec_t        viol,
   output rule_vec_t        flags,
   output rule_code_t       first,
   output logic [CNT_W-1:0] cnt
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags <= '0;
         first <= '0;
         cnt   <= '0;
      end else if (valid) begin
         flags <= flags | viol;
         if (first == '0) first <= first_code(viol);
         if (cnt != '1) cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/trc_retire_checker.sv
module trc_retire_checker
   import trc_chk_pkg::*;
#(
   parameter int XLEN    = 64,
   parameter int INSN_W  = 64,
   parameter int ORDER_W = 64,
   parameter int RADDR_W = 5,
   parameter int CNT_W   = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 trc_valid,
   input  logic [ORDER_W-1:0]   trc_order,
   input  logic [XLEN-1:0]      trc_pc_pre,
   input  logic [XLEN-1:0]      trc_pc_post,
   input  logic [INSN_W-1:0]    trc_insn,
   input  logic                 trc_halt,
   input  logic                 trc_intr,
   input  logic [1:0]           trc_mode,
   input  logic [1:0]           trc_ixl,
   input  logic [RADDR_W-1:0]   trc_rd_addr,
   input  logic [XLEN-1:0]      trc_rd_data,
   input  logic [RADDR_W-1:0]   trc_rs1_addr,
   input  logic [XLEN-1:0]      trc_rs1_data,
   input  logic [RADDR_W-1:0]   trc_rs2_addr,
   input  logic [XLEN-1:0]      trc_rs2_data,
   output logic [NUM_RULES-1:0] err_flags,
   output logic [CODE_W-1:0]    err_first,
   output logic [CNT_W-1:0]     checked_cnt
);

   localparam int NUM_SRC = 2;

   if (INSN_W < 32) begin : g_bad_insn_w
      $error("INSN_W must be at least 32");
   end
   if (XLEN < 8) begin : g_bad_xlen
      $error("XLEN must be at least 8");
   end
   if (ORDER_W < 2) begin : g_bad_order_w
      $error("ORDER_W must be at least 2");
   end
   if (RADDR_W < 1 || CNT_W < 1) begin : g_bad_misc_w
      $error("RADDR_W and CNT_W must be positive");
   end

   rule_vec_t  fld_viol;
   rule_vec_t  seq_viol;
   rule_vec_t  all_viol;
   rule_vec_t  flags_q;
   rule_code_t first_q;

   trc_field_rules #(
      .XLEN    (XLEN),
      .INSN_W  (INSN_W),
      .RADDR_W (RADDR_W),
      .NUM_SRC (NUM_SRC)
   ) u_field (
      .insn    (trc_insn),
      .mode    (trc_mode),
      .ixl     (trc_ixl),
      .rd_addr (trc_rd_addr),
      .rd_data (trc_rd_data),
      .rs_addr ({trc_rs2_addr, trc_rs1_addr}),
      .rs_data ({trc_rs2_data, trc_rs1_data}),
      .viol    (fld_viol)
   );

   trc_seq_rules #(
      .XLEN    (XLEN),
      .ORDER_W (ORDER_W)
   ) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid   (trc_valid),
      .order   (trc_order),
      .pc_pre  (trc_pc_pre),
      .pc_post (trc_pc_post),
      .halt    (trc_halt),
      .intr    (trc_intr),
      .viol    (seq_viol)
   );

   assign all_viol = fld_viol | seq_viol;

   trc_err_log #(
      .CNT_W (CNT_W)
   ) u_log (
      .clk   (clk),
      .rst_n (rst_n),
      .valid (trc_valid),
      .viol  (all_viol),
      .flags (flags_q),
      .first (first_q),
      .cnt   (checked_cnt)
   );

   assign err_flags = flags_q;
   assign err_first = first_q;

endmodule

// File: rtl/trc_chk_sva.sv
module trc_chk_sva
   import trc_chk_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 trc_valid,
   input logic [1:0]           trc_mode,
   input logic [1:0]           trc_ixl,
   input logic [NUM_RULES-1:0] err_flags,
   input logic [CODE_W-1:0]    err_first,
   input logic [CNT_W-1:0]     checked_cnt
);

   AST_MODE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (trc_valid && trc_mode == MODE_RESERVED) |=> err_flags[RULE_MODE]); // R6

   AST_IXL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (trc_valid && trc_ixl != IXL_W32 && trc_ixl != IXL_W64) |=> err_flags[RULE_IXL]); // R7

   AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((err_flags & $past(err_flags)) == $past(err_flags))); // R9

   AST_FIRST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (err_first != '0) |=> $stable(err_first)); // R10

   AST_FIRST_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |-> ((err_first != '0) == (err_flags != '0))); // R10

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (trc_valid && checked_cnt != '1) |=> (checked_cnt == CNT_W'($past(checked_cnt) + 1'b1))); // R11

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !trc_valid |=> ($stable(err_flags) && $stable(checked_cnt) && $stable(err_first))); // R12

endmodule

bind trc_retire_checker trc_chk_sva #(.CNT_W(CNT_W)) u_sva (
   .clk         (clk),
   .rst_n       (rst_n),
   .trc_valid   (trc_valid),
   .trc_mode    (trc_mode),
   .trc_ixl     (trc_ixl),
   .err_flags   (err_flags),
   .err_first   (err_first),
   .checked_cnt (checked_cnt)
);

// File: tb/trc_retire_checker_tb_top.sv
module trc_retire_checker_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int XL = 32;
   localparam int IW = 64;
   localparam int OW = 8;
   localparam int RW = 5;
   localparam int CW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          trc_valid;
   logic [OW-1:0] trc_order;
   logic [XL-1:0] trc_pc_pre, trc_pc_post;
   logic [IW-1:0] trc_insn;
   logic          trc_halt, trc_intr;
   logic [1:0]    trc_mode, trc_ixl;
   logic [RW-1:0] trc_rd_addr, trc_rs1_addr, trc_rs2_addr;
   logic [XL-1:0] trc_rd_data, trc_rs1_data, trc_rs2_data;
   logic [7:0]    err_flags;
   logic [3:0]    err_first;
   logic [CW-1:0] checked_cnt;

   trc_retire_checker #(
      .XLEN(XL), .INSN_W(IW), .ORDER_W(OW), .RADDR_W(RW), .CNT_W(CW)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .trc_valid(trc_valid), .trc_order(trc_order),
      .trc_pc_pre(trc_pc_pre), .trc_pc_post(trc_pc_post), .trc_insn(trc_insn),
      .trc_halt(trc_halt), .trc_intr(trc_intr), .trc_mode(trc_mode), .trc_ixl(trc_ixl),
      .trc_rd_addr(trc_rd_addr), .trc_rd_data(trc_rd_data),
      .trc_rs1_addr(trc_rs1_addr), .trc_rs1_data(trc_rs1_data),
      .trc_rs2_addr(trc_rs2_addr), .trc_rs2_data(trc_rs2_data),
      .err_flags(err_flags), .err_first(err_first), .checked_cnt(checked_cnt)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   typedef struct {
      logic          v;
      logic [OW-1:0] order;
      logic [XL-1:0] pc_pre, pc_post;
      logic [IW-1:0] insn;
      logic          halt, intr;
      logic [1:0]    mode, ixl;
      logic [RW-1:0] rd, rs1, rs2;
      logic [XL-1:0] rdd, rs1d, rs2d;
   } rec_t;

   int n_checks = 0;
   int n_err = 0;
   bit done = 0;

   // reference model state
   logic [7:0]    m_flags;
   logic [3:0]    m_first;
   int            m_cnt;
   bit            m_have, m_halted;
   logic [OW-1:0] m_prev_order;
   logic [XL-1:0] m_prev_post;
   logic [OW-1:0] nx_order;
   logic [XL-1:0] nx_pc;

   function automatic rec_t good();
      rec_t r;
      r.v = 1'b1; r.order = nx_order; r.pc_pre = nx_pc; r.pc_post = nx_pc + 32'd4;
      r.insn = 64'h0000_0000_0051_0093; r.halt = 1'b0; r.intr = 1'b0;
      r.mode = 2'd3; r.ixl = 2'd1;
      r.rd = 5'd1; r.rdd = 32'h1234; r.rs1 = 5'd2; r.rs1d = 32'h55;
      r.rs2 = 5'd0; r.rs2d = 32'h0;
      return r;
   endfunction

   task automatic check(string tag);
      n_checks++;
      if (err_flags !== m_flags || err_first !== m_first || checked_cnt !== CW'(m_cnt)) begin
         n_err++;
         $display("FAIL %s: flags=%b first=%0d cnt=%0d expected flags=%b first=%0d cnt=%0d",
                  tag, err_flags, err_first, checked_cnt, m_flags, m_first, m_cnt);
      end
   endtask

   task automatic apply(rec_t r);
      trc_valid = r.v; trc_order = r.order; trc_pc_pre = r.pc_pre; trc_pc_post = r.pc_post;
      trc_insn = r.insn; trc_halt = r.halt; trc_intr = r.intr; trc_mode = r.mode; trc_ixl = r.ixl;
      trc_rd_addr = r.rd; trc_rd_data = r.rdd; trc_rs1_addr = r.rs1; trc_rs1_data = r.rs1d;
      trc_rs2_addr = r.rs2; trc_rs2_data = r.rs2d;
   endtask

   task automatic retire(rec_t r, string tag);
      logic [7:0]    viol;
      logic [OW-1:0] want;
      logic [3:0]    cand;
      viol = '0;
      cand = '0;
      want = m_prev_order + 1'b1;
      apply(r);
      if (r.v) begin
         if (m_have && r.order != want) viol[0] = 1'b1;
         if (m_have && (r.intr != (r.pc_pre != m_prev_post))) viol[1] = 1'b1;
         if (r.rd == 0 && r.rdd != 0) viol[2] = 1'b1;
         if ((r.rs1 == 0 && r.rs1d != 0) || (r.rs2 == 0 && r.rs2d != 0)) viol[3] = 1'b1;
         if (r.insn[1:0] != 2'b11) begin
            if (r.insn[63:16] != 0) viol[4] = 1'b1;
         end else if (r.insn[63:32] != 0) viol[4] = 1'b1;
         if (r.mode == 2'd2) viol[5] = 1'b1;
         if (r.ixl != 2'd1 && r.ixl != 2'd2) viol[6] = 1'b1;
         if (m_halted) viol[7] = 1'b1;
         for (int i = 7; i >= 0; i--) if (viol[i]) cand = 4'(i + 1);
         if (m_first == 0) m_first = cand;
         m_flags = m_flags | viol;
         if (m_cnt < (1 << CW) - 1) m_cnt++;
         m_have = 1; m_prev_order = r.order; m_prev_post = r.pc_post;
         if (r.halt) m_halted = 1;
         nx_order = r.order + 1'b1;
         nx_pc = r.pc_post;
      end
      @(negedge clk);
      check(tag);
   endtask

   task automatic do_reset();
      rec_t r;
      r = good();
      r.v = 1'b0;
      apply(r);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      m_flags = '0; m_first = '0; m_cnt = 0; m_have = 0; m_halted = 0;
      m_prev_order = '0; m_prev_post = '0;
      rst_n = 1'b1;
      @(negedge clk);
      check("R9 reset state");
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_checks++;
         n_err++;
         $display("FAIL watchdog: run hung, actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_err, n_checks);
         $finish;
      end
   end

   initial begin
      rec_t r;
      nx_order = 8'd40;
      nx_pc = 32'h100;
      do_reset();

      // clean patterns
      r = good(); retire(r, "R11 first retirement counted");
      r = good(); r.rd = 0; r.rdd = 0; retire(r, "R3 rd zero with zero data");
      r = good(); r.insn = 64'h4501; r.pc_post = r.pc_pre + 32'd2; retire(r, "R5 clean short word");
      r = good(); r.pc_pre = 32'h2000; r.pc_post = 32'h2004; r.intr = 1; retire(r, "R2 intr on redirect");
      r = good(); r.mode = 0; retire(r, "R6 user mode legal");
      r = good(); r.mode = 1; r.ixl = 2; retire(r, "R7 ixl 64 legal");
      r = good(); r.v = 0; r.mode = 2; r.rd = 0; r.rdd = 32'hFFFF; r.order = 8'h99;
      r.pc_pre = 32'h7777; retire(r, "R12 idle fields ignored");
      r = good(); retire(r, "R12 history untouched by idle");

      // order wrap, skip, resync
      do_reset();
      nx_order = 8'hFE;
      r = good(); retire(r, "R1 before wrap");
      r = good(); retire(r, "R1 at 255");
      r = good(); retire(r, "R1 wrap to 0");
      r = good(); r.order = r.order + 8'd2; retire(r, "R1 skipped index");
      r = good(); retire(r, "R1 resync after skip");
      r = good(); r.pc_pre = 32'h3000; r.pc_post = 32'h3004; retire(r, "R2 missing intr, R10 first kept");

      do_reset();
      r = good(); retire(r, "R1 setup");
      r = good(); r.order = r.order - 8'd1; retire(r, "R1 repeated index");

      do_reset();
      r = good(); r.order = 8'h77; r.pc_pre = 32'h9000; r.pc_post = 32'h9004; r.intr = 1;
      retire(r, "R1 R2 first retirement exempt");
      r = good(); r.intr = 1; retire(r, "R2 spurious intr");

      do_reset();
      r = good(); r.rd = 0; r.rdd = 32'd5; retire(r, "R3 rd zero with data");
      do_reset();
      r = good(); r.rs2 = 0; r.rs2d = 32'd1; retire(r, "R4 rs2 zero with data");
      do_reset();
      r = good(); r.rs1 = 0; r.rs1d = 32'd7; retire(r, "R4 rs1 zero with data");
      do_reset();
      r = good(); r.insn = 64'h0010_4501; r.pc_post = r.pc_pre + 32'd2; retire(r, "R5 short word upper bit");
      do_reset();
      r = good(); r.insn = 64'h0000_0100_0051_0093; retire(r, "R5 full word upper bit");

      do_reset();
      r = good(); r.mode = 2; r.ixl = 3; retire(r, "R10 lowest rule wins, R6 R7");
      r = good(); r.rd = 0; r.rdd = 32'd9; retire(r, "R9 accumulate, R10 hold");
      do_reset();
      r = good(); r.ixl = 0; retire(r, "R7 ixl zero");

      do_reset();
      r = good(); r.halt = 1; retire(r, "R8 halting retirement clean");
      r = good(); r.v = 0; retire(r, "R8 idle after halt");
      r = good(); retire(r, "R8 retirement after halt");

      do_reset();
      for (int i = 0; i < 70; i++) begin
         r = good(); retire(r, "R11 saturating count");
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end

endmodule